// File: doc/BRIEF.md
# Parallel CRC-8 Frame Checker

This block sits on the receive side of a framed link and verifies an 8-bit CRC carried with each frame. Payload arrives as 16-bit words. Each word qualified by the valid strobe is folded into the running CRC in a single clock, so the whole word is absorbed at once. A start strobe on a word restarts the computation from a seed value. An end strobe on a word closes the frame, and on that same cycle the block samples the CRC that came with the frame.

One clock after the closing word, the block raises a single-cycle done strobe together with a pass/fail verdict. The CRC computed over the payload stays visible on its own output. A mode input picks one of two equivalent checks:
- a direct comparison of the computed CRC against the received one, or
- a residue check, which runs the received CRC through the same polynomial after the payload and accepts the frame only when the remainder is zero.

The seed is a parameter and must match the one used by the transmitter. No output XOR and no bit reflection are applied.

Top module: `crc8_frame_chk`

## Requirements
- R1: The CRC uses generator x^8+x^4+x^3+x^2+1 (low byte 0x1D), with no bit reflection and no output XOR. After a frame's closing word, crc_o equals the remainder of the payload bits shifted in from the seed.
- R2: Each valid word is folded in whole in one clock, with word_i[15] entering first and word_i[0] last.
- R3: A word with sof_i=1 and vld_i=1 starts from SEED rather than the register, so any earlier partial frame is discarded. A frame whose only word carries both sof_i and eof_i is checked normally.
- R4: When vld_i=0, the CRC register holds its value, and sof_i, eof_i and word_i have no effect on crc_o or done_o.
- R5: While rst_ni=0 (asynchronous, active low), crc_o=0x00, done_o=0 and pass_o=0, whatever the SEED value.
- R6: done_o is 1 for exactly the one cycle after a cycle with vld_i=1 and eof_i=1, and 0 in every other cycle.
- R7: With mode_i=0 (compare), pass_o=1 exactly when the payload CRC equals rx_crc_i sampled on the closing word.
- R8: With mode_i=1 (residue), rx_crc_i is folded in MSB first after the payload in the same cycle. pass_o=1 exactly when the resulting remainder is 0x00.
- R9: pass_o is registered with done_o and holds its value until the next done_o.
- R10: rx_crc_i and mode_i are sampled only on the closing word (vld_i=1, eof_i=1). Their values in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | First word of frame (qualified by vld_i) |
| eof_i | input | 1 | Last word of frame (qualified by vld_i) |
| vld_i | input | 1 | Word valid strobe |
| word_i | input | 16 | Payload word, bit 15 first |
| rx_crc_i | input | 8 | Received CRC, sampled on the closing word |
| mode_i | input | 1 | 0 = compare, 1 = zero-residue check |
| done_o | output | 1 | One-cycle verdict strobe |
| pass_o | output | 1 | Verdict, held until the next done_o |
| crc_o | output | 8 | Running / final payload CRC |

## Verification
A corrupted CRC register or a wrong feedback term shows up on crc_o on the clock after the first affected word. It also flips pass_o on that frame's done_o strobe, one cycle after the closing word. The bench sweeps all 256 received CRC values in both modes against a bit-serial model, so exactly one value must pass. A stray done_o or a drifting pass_o is visible in the idle cycle that follows every frame.

// File: rtl/crc8_chk_pkg.sv
package crc8_chk_pkg;
  localparam int unsigned CRC_W  = 8;
  localparam int unsigned WORD_W = 16;
  localparam logic [CRC_W-1:0] POLY_DEF = 8'h1D;

  typedef enum logic {
    CHK_COMPARE = 1'b0,
    CHK_RESIDUE = 1'b1
  } chk_mode_e;
endpackage

// File: rtl/crc_fold.sv
// Combinational MSB-first fold of IN_W data bits into a CRC_W remainder.
module crc_fold #(
  parameter int unsigned CRC_W = 8,
  parameter int unsigned IN_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 8'h1D
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [CRC_W-1:0] crc_o
);
  for (genvar i = 0; i < IN_W; i++) begin : g_bit
    logic [CRC_W-1:0] prv, nxt;
    logic             fb;
    if (i == 0) begin : g_head
      assign prv = crc_i;
    end else begin : g_link
      assign prv = g_bit[i-1].nxt;
    end
    assign fb  = prv[CRC_W-1] ^ data_i[IN_W-1-i];
    assign nxt = {prv[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
  assign crc_o = g_bit[IN_W-1].nxt;
endmodule

// File: rtl/crc_acc.sv
// Running CRC register with seed restart on start-of-frame.
module crc_acc #(
  parameter int unsigned CRC_W  = 8,
  parameter int unsigned WORD_W = 16,
  parameter logic [CRC_W-1:0] POLY = 8'h1D,
  parameter logic [CRC_W-1:0] SEED = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CRC_W-1:0]  crc_next_o,
  output logic [CRC_W-1:0]  crc_q_o
);
  logic [CRC_W-1:0] crc_q, crc_base;

  assign crc_base = sof_i ? SEED : crc_q;

  crc_fold #(.CRC_W(CRC_W), .IN_W(WORD_W), .POLY(POLY)) u_word_fold (
    .crc_i (crc_base),
    .data_i(word_i),
    .crc_o (crc_next_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (vld_i) crc_q <= crc_next_o;
  end

  assign crc_q_o = crc_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(crc_q));
endmodule

// File: rtl/chk_verdict.sv
// Frame-end verdict: compare or zero-residue, registered with a done strobe.
module chk_verdict
  import crc8_chk_pkg::*;
#(
  parameter int unsigned CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h1D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fin_i,
  input  logic             mode_i,
  input  logic [CRC_W-1:0] crc_next_i,
  input  logic [CRC_W-1:0] rx_crc_i,
  output logic             done_o,
  output logic             pass_o
);
  logic [CRC_W-1:0] residue;
  logic             verdict;
  chk_mode_e        mode;

  assign mode = chk_mode_e'(mode_i);

  crc_fold #(.CRC_W(CRC_W), .IN_W(CRC_W), .POLY(POLY)) u_res_fold (
    .crc_i (crc_next_i),
    .data_i(rx_crc_i),
    .crc_o (residue)
  );

  always_comb begin
    unique case (mode)
      CHK_RESIDUE: verdict = (residue == '0);
      default:     verdict = (crc_next_i == rx_crc_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (fin_i) pass_o <= verdict;
    end
  end

  assert_done_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> done_o);
  assert_done_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> !done_o);
  assert_pass_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(pass_o));
  assert_residue_agree_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && crc_next_i == rx_crc_i) |-> (residue == '0));
endmodule

// File: rtl/crc8_frame_chk.sv
module crc8_frame_chk
  import crc8_chk_pkg::*;
#(
  parameter logic [CRC_W-1:0] SEED = 8'h00,
  parameter logic [CRC_W-1:0] POLY = POLY_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CRC_W-1:0]  rx_crc_i,
  input  logic              mode_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_next;
  logic             fin;

  assign fin = vld_i & eof_i;

  crc_acc #(.CRC_W(CRC_W), .WORD_W(WORD_W), .POLY(POLY), .SEED(SEED)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .vld_i     (vld_i),
    .word_i    (word_i),
    .crc_next_o(crc_next),
    .crc_q_o   (crc_o)
  );

  chk_verdict #(.CRC_W(CRC_W), .POLY(POLY)) u_verdict (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fin_i     (fin),
    .mode_i    (mode_i),
    .crc_next_i(crc_next),
    .rx_crc_i  (rx_crc_i),
    .done_o    (done_o),
    .pass_o    (pass_o)
  );
endmodule

// File: tb/crc8_frame_chk_bench.sv
module crc8_frame_chk_bench;
  localparam logic [7:0] SEED = 8'h3C;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sof, eof, vld, mode;
  logic [15:0] word;
  logic [7:0]  rx_crc;
  logic done, pass;
  logic [7:0] crc;
  int n_run = 0, n_fail = 0;
  logic [15:0] w [8];

  always #5 clk = ~clk;

  crc8_frame_chk #(.SEED(SEED)) u_crc8_frame_chk (
    .clk_i(clk), .rst_ni(rst_ni), .sof_i(sof), .eof_i(eof), .vld_i(vld),
    .word_i(word), .rx_crc_i(rx_crc), .mode_i(mode),
    .done_o(done), .pass_o(pass), .crc_o(crc));

  // bit-serial reference, MSB first, poly 0x1D
  function automatic logic [7:0] ref_shift(logic [7:0] c, logic [15:0] d, int n);
    for (int k = n - 1; k >= 0; k--) begin
      logic fb;
      fb = c[7] ^ d[k];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_frame(int n);
    logic [7:0] c = SEED;
    for (int k = 0; k < n; k++) c = ref_shift(c, w[k], 16);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sof = 0; eof = 0; vld = 0; word = 16'($urandom); rx_crc = 8'($urandom); mode = 1'($urandom);
  endtask

  // drive frame w[0..n-1]; check verdict, payload CRC, strobe width and hold
  task automatic run_frame(input int n, input logic m, input logic [7:0] rxc, input bit exp_pass);
    logic [7:0] exp_crc;
    logic held;
    exp_crc = ref_frame(n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      vld = 1; sof = (k == 0); eof = (k == n - 1); word = w[k];
      rx_crc = (k == n - 1) ? rxc : 8'($urandom);      // R10 junk elsewhere
      mode   = (k == n - 1) ? m   : 1'($urandom);
    end
    @(negedge clk);
    idle_inputs();
    sof = 1; eof = 1;                                   // R4: ignored without vld
    check(done === 1'b1, "R6 done after closing word", 32'(done), 1);
    check(pass === exp_pass, m ? "R8 residue verdict" : "R7 compare verdict", 32'(pass), 32'(exp_pass));
    check(crc === exp_crc, "R1 R2 payload crc", 32'(crc), 32'(exp_crc));
    held = pass;
    @(negedge clk);
    idle_inputs();
    check(done === 1'b0, "R6 single-cycle done", 32'(done), 0);
    check(pass === held, "R9 pass holds", 32'(pass), 32'(held));
    check(crc === exp_crc, "R4 crc holds while idle", 32'(crc), 32'(exp_crc));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] good, bad;
    int n;
    idle_inputs();
    sof = 1; eof = 1; vld = 1;
    repeat (3) @(negedge clk);
    check(crc === 8'h00, "R5 reset crc", 32'(crc), 0);
    check(done === 1'b0, "R5 reset done", 32'(done), 0);
    check(pass === 1'b0, "R5 reset pass", 32'(pass), 0);
    idle_inputs();
    rst_ni = 1;
    @(negedge clk);
    check(done === 1'b0 && crc === 8'h00, "R5 idle after reset", 32'({done, crc}), 0);

    // exhaustive rx_crc sweep on single-word frames (sof and eof together), R3
    w[0] = 16'hB7E1;
    good = ref_frame(1);
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 256; r++)
        run_frame(1, 1'(m), 8'(r), 8'(r) == good);

    // random good frames, 1..8 words, both modes
    for (int t = 0; t < 200; t++) begin
      n = 1 + ($urandom % 8);
      for (int k = 0; k < 8; k++) w[k] = 16'($urandom);
      run_frame(n, 1'(t & 1), ref_frame(n), 1'b1);
    end

    // single-bit error injection always fails
    for (int t = 0; t < 200; t++) begin
      int pos;
      n = 1 + ($urandom % 8);
      for (int k = 0; k < 8; k++) w[k] = 16'($urandom);
      good = ref_frame(n);
      pos = $urandom % (16 * n + 8);
      bad = good;
      if (pos < 16 * n) w[pos / 16][pos % 16] = ~w[pos / 16][pos % 16];
      else bad[pos - 16 * n] = ~bad[pos - 16 * n];
      run_frame(n, 1'(t & 1), bad, 1'b0);
    end

    // R3 restart: abandoned partial frame, then a new frame with sof
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      vld = 1; sof = 1; eof = 0; word = 16'($urandom);
      @(negedge clk);
      sof = 0; word = 16'($urandom);
      n = 1 + ($urandom % 4);
      for (int k = 0; k < 8; k++) w[k] = 16'($urandom);
      run_frame(n, 1'(t & 1), ref_frame(n), 1'b1);
    end

    // R4: invalid cycles with strobes set leave crc and done untouched
    good = crc;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      vld = 0; sof = 1; eof = 1; word = 16'($urandom);
      @(negedge clk);
      check(crc === good && done === 1'b0, "R4 ignored without vld", 32'({done, crc}), 32'(good));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule